// File: doc/BRIEF.md
# SDRAM Power-On Initialization Sequencer

This block sits on the controller side of an SDRAM interface. After reset it runs the start-up procedure that the memory needs before any read or write traffic is allowed. It holds the clock enable and all data masks high and sends only no-operation commands for a long stabilisation wait. It then closes every bank with one precharge-all command. Next it issues a programmable number of auto-refresh commands, and last it loads the mode register from the `mode_cfg` input.

Every wait is given in nanoseconds and converted at elaboration to a whole number of clock cycles, rounded up from the clock-period parameter. A single down-counter times every wait, and no-operation commands fill every cycle in which the block is waiting. When the mode-set recovery time has passed, `init_done` rises and stays high. The surrounding controller then takes over the command bus. An optional output register stage, chosen by parameter, delays every output pin by one cycle.

Top module: `sdram_boot_seq`

## Requirements
- R1: While `rst` is high and until `init_done` rises, `sd_cke` is 1, every bit of `sd_dqm` is 1 and `init_done` is 0.
- R2: After reset is released, only no-operation commands appear for STABLE_CYC cycles. The first other command is precharge-all, driven with address bit 10 at 1 and every other address bit at 0.
- R3: The first auto-refresh follows the precharge-all by exactly RP_CYC cycles.
- R4: Exactly REFRESH_COUNT auto-refresh commands are issued, at least 8, each one RFC_CYC cycles after the one before it.
- R5: The mode-set command comes RFC_CYC cycles after the last refresh. It carries `mode_cfg` in address bits [MODE_W-1:0], zero in all other address bits (including bits 9..7) and bank 0.
- R6: `init_done` rises exactly RSC_CYC cycles after the mode-set command, then stays high with only no-operation commands on the bus.
- R7: Reset asserted in any cycle returns the bus to no-operation and clears `init_done` on the next clock edge. The whole sequence restarts once reset is released.
- R8: Command codes on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} are: no-operation 0111, precharge-all 0010, auto-refresh 0001, mode-set 0000. Every wait cycle carries no-operation.
- R9: Each cycle count is ceil(ns × 1000 / CLK_PERIOD_PS) for its nanosecond parameter (STABLE_NS, TRP_NS, TRFC_NS, TRSC_NS). With REG_OUT=1, every output appears one cycle later than with REG_OUT=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| mode_cfg | input | MODE_W | Value written to the mode register |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Address bus |
| sd_dqm | output | DQM_W | Data masks, held high during start-up |
| init_done | output | 1 | High once the memory is idle and ready |

## Verification
The mode-address check assumes that `mode_cfg` stays constant from reset release until the mode-set command reaches the pins. This matters because the registered output variant samples `mode_cfg` one cycle before the command appears. The bench sets the mode value while reset is held and changes it only between runs. The gap checks assume that no other agent drives the bus until `init_done` is high. The bench therefore observes only this block's pins. It sweeps reset assertion across every third cycle of the sequence, so each restart begins from a different phase.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

   typedef enum logic [2:0] {
      PH_STABLE,
      PH_PREA,
      PH_WAIT_RP,
      PH_REF,
      PH_WAIT_RFC,
      PH_MRS,
      PH_WAIT_RSC,
      PH_DONE
   } boot_phase_e;

   typedef enum logic [1:0] {
      CMD_NOP,
      CMD_PREA,
      CMD_REF,
      CMD_MRS
   } boot_cmd_e;

   // whole clock cycles covering a time in ns, rounded up
   function automatic int ns_to_cyc(input int ns, input int period_ps);
      return (ns * 1000 + period_ps - 1) / period_ps;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
   parameter int CNT_W   = 16,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= CNT_W'(RST_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/boot_cmd_drive.sv
module boot_cmd_drive
   import sdram_boot_pkg::*;
#(
   parameter int ROW_W   = 12,
   parameter int BANK_W  = 2,
   parameter int DQM_W   = 8,
   parameter int MODE_W  = 7,
   parameter int REG_OUT = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  boot_cmd_e         cmd,
   input  logic [MODE_W-1:0] mode_cfg,
   input  logic              done_in,
   output logic              sd_cke,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ROW_W-1:0]  sd_addr,
   output logic [DQM_W-1:0]  sd_dqm,
   output logic              init_done
);

   localparam int ALL_BANK_BIT = 10;

   logic [3:0]        c_code;
   logic [ROW_W-1:0]  c_addr;

   always_comb begin
      c_code = 4'b0111;
      c_addr = '0;
      unique case (cmd)
         CMD_PREA: begin
            c_code               = 4'b0010;
            c_addr[ALL_BANK_BIT] = 1'b1;
         end
         CMD_REF:  c_code = 4'b0001;
         CMD_MRS: begin
            c_code = 4'b0000;
            c_addr = ROW_W'(mode_cfg);
         end
         default:  c_code = 4'b0111;
      endcase
   end

   generate
      if (REG_OUT != 0) begin : g_reg
         logic [3:0]       code_q;
         logic [ROW_W-1:0] addr_q;
         logic             done_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               code_q <= 4'b0111;
               addr_q <= '0;
               done_q <= 1'b0;
            end else begin
               code_q <= c_code;
               addr_q <= c_addr;
               done_q <= done_in;
            end
         end
         assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = code_q;
         assign sd_addr   = addr_q;
         assign init_done = done_q;
      end else begin : g_comb
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst;
         assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = c_code;
         assign sd_addr   = c_addr;
         assign init_done = done_in;
      end
   endgenerate

   assign sd_cke = 1'b1;
   assign sd_ba  = '0;
   assign sd_dqm = '1;

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
   import sdram_boot_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 7500,
   parameter int STABLE_NS     = 200000,
   parameter int TRP_NS        = 20,
   parameter int TRFC_NS       = 75,
   parameter int TRSC_NS       = 15,
   parameter int REFRESH_COUNT = 8,
   parameter int ROW_W         = 12,
   parameter int BANK_W        = 2,
   parameter int DQM_W         = 8,
   parameter int MODE_W        = 7,
   parameter int REG_OUT       = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [MODE_W-1:0] mode_cfg,
   output logic              sd_cke,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ROW_W-1:0]  sd_addr,
   output logic [DQM_W-1:0]  sd_dqm,
   output logic              init_done
);

   localparam int STABLE_CYC = ns_to_cyc(STABLE_NS, CLK_PERIOD_PS);
   localparam int RP_CYC     = ns_to_cyc(TRP_NS, CLK_PERIOD_PS);
   localparam int RFC_CYC    = ns_to_cyc(TRFC_NS, CLK_PERIOD_PS);
   localparam int RSC_CYC    = ns_to_cyc(TRSC_NS, CLK_PERIOD_PS);
   localparam int MAX_CYC    = max2(max2(STABLE_CYC, RP_CYC), max2(RFC_CYC, RSC_CYC));
   localparam int CNT_W      = $clog2(MAX_CYC + 1);
   localparam int REF_W      = $clog2(REFRESH_COUNT + 1);
   localparam int RP_LD      = (RP_CYC  > 1) ? RP_CYC  - 2 : 0;
   localparam int RFC_LD     = (RFC_CYC > 1) ? RFC_CYC - 2 : 0;
   localparam int RSC_LD     = (RSC_CYC > 1) ? RSC_CYC - 2 : 0;

   generate
      if (CLK_PERIOD_PS <= 0) begin : g_bad_period
         $error("CLK_PERIOD_PS must be positive");
      end
      if (STABLE_NS <= 0 || TRP_NS <= 0 || TRFC_NS <= 0 || TRSC_NS <= 0) begin : g_bad_time
         $error("every wait time must be positive");
      end
      if (REFRESH_COUNT < 8) begin : g_bad_refs
         $error("REFRESH_COUNT must be at least 8");
      end
      if (ROW_W < 11) begin : g_bad_row
         $error("ROW_W must reach address bit 10");
      end
      if (MODE_W < 1 || MODE_W > 7) begin : g_bad_mode
         $error("MODE_W must be 1..7 so bits 9..7 stay zero");
      end
      if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
         $error("REG_OUT must be 0 or 1");
      end
   endgenerate

   boot_phase_e       phase_q, phase_d;
   boot_cmd_e         cmd;
   logic [REF_W-1:0]  ref_cnt_q;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic              tmr_zero;
   logic              last_ref;
   logic              refs_done;

   assign last_ref  = (ref_cnt_q == REF_W'(REFRESH_COUNT - 1));
   assign refs_done = (ref_cnt_q == REF_W'(REFRESH_COUNT));

   boot_wait_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (STABLE_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   always_comb begin
      phase_d  = phase_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      cmd      = CMD_NOP;
      unique case (phase_q)
         PH_STABLE:   if (tmr_zero) phase_d = PH_PREA;
         PH_PREA: begin
            cmd      = CMD_PREA;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RP_LD);
            phase_d  = (RP_CYC > 1) ? PH_WAIT_RP : PH_REF;
         end
         PH_WAIT_RP:  if (tmr_zero) phase_d = PH_REF;
         PH_REF: begin
            cmd      = CMD_REF;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RFC_LD);
            if (RFC_CYC > 1) phase_d = PH_WAIT_RFC;
            else             phase_d = last_ref ? PH_MRS : PH_REF;
         end
         PH_WAIT_RFC: if (tmr_zero) phase_d = refs_done ? PH_MRS : PH_REF;
         PH_MRS: begin
            cmd      = CMD_MRS;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RSC_LD);
            phase_d  = (RSC_CYC > 1) ? PH_WAIT_RSC : PH_DONE;
         end
         PH_WAIT_RSC: if (tmr_zero) phase_d = PH_DONE;
         PH_DONE:     phase_d = PH_DONE;
         default:     phase_d = PH_STABLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q   <= PH_STABLE;
         ref_cnt_q <= '0;
      end else begin
         phase_q <= phase_d;
         if (phase_q == PH_REF)
            ref_cnt_q <= ref_cnt_q + REF_W'(1);
      end
   end

   boot_cmd_drive #(
      .ROW_W   (ROW_W),
      .BANK_W  (BANK_W),
      .DQM_W   (DQM_W),
      .MODE_W  (MODE_W),
      .REG_OUT (REG_OUT)
   ) u_drive (
      .clk       (clk),
      .rst       (rst),
      .cmd       (cmd),
      .mode_cfg  (mode_cfg),
      .done_in   (phase_q == PH_DONE),
      .sd_cke    (sd_cke),
      .sd_cs_n   (sd_cs_n),
      .sd_ras_n  (sd_ras_n),
      .sd_cas_n  (sd_cas_n),
      .sd_we_n   (sd_we_n),
      .sd_ba     (sd_ba),
      .sd_addr   (sd_addr),
      .sd_dqm    (sd_dqm),
      .init_done (init_done)
   );

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk
   import sdram_boot_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 7500,
   parameter int STABLE_NS     = 200000,
   parameter int TRP_NS        = 20,
   parameter int TRFC_NS       = 75,
   parameter int TRSC_NS       = 15,
   parameter int REFRESH_COUNT = 8,
   parameter int ROW_W         = 12,
   parameter int BANK_W        = 2,
   parameter int DQM_W         = 8,
   parameter int MODE_W        = 7
) (
   input logic              clk,
   input logic              rst,
   input logic [MODE_W-1:0] mode_cfg,
   input logic              sd_cke,
   input logic              sd_cs_n,
   input logic              sd_ras_n,
   input logic              sd_cas_n,
   input logic              sd_we_n,
   input logic [BANK_W-1:0] sd_ba,
   input logic [ROW_W-1:0]  sd_addr,
   input logic [DQM_W-1:0]  sd_dqm,
   input logic              init_done
);

   localparam int STABLE_CYC = ns_to_cyc(STABLE_NS, CLK_PERIOD_PS);
   localparam int RP_CYC     = ns_to_cyc(TRP_NS, CLK_PERIOD_PS);
   localparam int RFC_CYC    = ns_to_cyc(TRFC_NS, CLK_PERIOD_PS);
   localparam int RSC_CYC    = ns_to_cyc(TRSC_NS, CLK_PERIOD_PS);
   localparam logic [3:0] C_NOP  = 4'b0111;
   localparam logic [3:0] C_PREA = 4'b0010;
   localparam logic [3:0] C_REF  = 4'b0001;
   localparam logic [3:0] C_MRS  = 4'b0000;

   logic [3:0]  code;
   logic [3:0]  last_q;
   logic [31:0] since_rst_q;
   logic [31:0] gap_q;
   logic [7:0]  nref_q;
   logic        seen_q;

   assign code = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   always_ff @(posedge clk) begin
      if (rst) begin
         since_rst_q <= '0;
         gap_q       <= '0;
         last_q      <= C_NOP;
         nref_q      <= '0;
         seen_q      <= 1'b0;
      end else begin
         if (since_rst_q != '1) since_rst_q <= since_rst_q + 32'd1;
         if (code != C_NOP) begin
            gap_q  <= 32'd1;
            last_q <= code;
            seen_q <= 1'b1;
         end else if (gap_q != '1) begin
            gap_q <= gap_q + 32'd1;
         end
         if (code == C_REF && nref_q != '1) nref_q <= nref_q + 8'd1;
      end
   end

   // R1
   busy_pins_chk: assert property (@(posedge clk) disable iff (rst)
      !init_done |-> (sd_cke && (&sd_dqm)));
   // R8
   cmd_legal_chk: assert property (@(posedge clk) disable iff (rst)
      (code == C_NOP || code == C_PREA || code == C_REF || code == C_MRS));
   // R2
   stable_wait_chk: assert property (@(posedge clk) disable iff (rst)
      (code != C_NOP) |-> (since_rst_q >= 32'(STABLE_CYC)));
   // R2
   first_prea_chk: assert property (@(posedge clk) disable iff (rst)
      (code != C_NOP && !seen_q) |-> (code == C_PREA && sd_addr[10]));
   // R3
   rp_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (code != C_NOP && last_q == C_PREA) |-> (gap_q >= 32'(RP_CYC)));
   // R4
   rfc_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (code != C_NOP && last_q == C_REF) |-> (gap_q >= 32'(RFC_CYC)));
   // R5
   refs_first_chk: assert property (@(posedge clk) disable iff (rst)
      (code == C_MRS) |-> (nref_q >= 8'(REFRESH_COUNT)));
   // R5
   mrs_addr_chk: assert property (@(posedge clk) disable iff (rst)
      (code == C_MRS) |-> (sd_addr == ROW_W'(mode_cfg) && sd_ba == '0));
   // R6
   done_gap_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(init_done) |-> (last_q == C_MRS && gap_q >= 32'(RSC_CYC)));
   // R6
   done_hold_chk: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);
   // R6
   done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      init_done |-> (code == C_NOP));

endmodule

bind sdram_boot_seq boot_seq_chk #(
   .CLK_PERIOD_PS (CLK_PERIOD_PS),
   .STABLE_NS     (STABLE_NS),
   .TRP_NS        (TRP_NS),
   .TRFC_NS       (TRFC_NS),
   .TRSC_NS       (TRSC_NS),
   .REFRESH_COUNT (REFRESH_COUNT),
   .ROW_W         (ROW_W),
   .BANK_W        (BANK_W),
   .DQM_W         (DQM_W),
   .MODE_W        (MODE_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .mode_cfg  (mode_cfg),
   .sd_cke    (sd_cke),
   .sd_cs_n   (sd_cs_n),
   .sd_ras_n  (sd_ras_n),
   .sd_cas_n  (sd_cas_n),
   .sd_we_n   (sd_we_n),
   .sd_ba     (sd_ba),
   .sd_addr   (sd_addr),
   .sd_dqm    (sd_dqm),
   .init_done (init_done)
);

// File: tb/sim_sdram_boot_seq.sv
module sim_sdram_boot_seq;

   localparam int CLK_NS = 10;
   localparam int PER_PS = 10000;
   localparam int ST_NS  = 95;
   localparam int RP_NS  = 15;
   localparam int RFC_NS = 72;
   localparam int RSC_NS = 20;
   localparam int NREF   = 8;
   localparam int LAT    = 1;

   // R9: ceil(ns*1000/period)
   localparam int S = (ST_NS  * 1000 + PER_PS - 1) / PER_PS;
   localparam int P = (RP_NS  * 1000 + PER_PS - 1) / PER_PS;
   localparam int F = (RFC_NS * 1000 + PER_PS - 1) / PER_PS;
   localparam int M = (RSC_NS * 1000 + PER_PS - 1) / PER_PS;
   localparam int MRS_AT = S + P + NREF * F;
   localparam int END_AT = MRS_AT + M + LAT + 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [6:0]  mode = '0;
   logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
   logic [1:0]  sd_ba;
   logic [11:0] sd_addr;
   logic [7:0]  sd_dqm;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_NS / 2) clk = ~clk;

   sdram_boot_seq #(
      .CLK_PERIOD_PS (PER_PS),
      .STABLE_NS     (ST_NS),
      .TRP_NS        (RP_NS),
      .TRFC_NS       (RFC_NS),
      .TRSC_NS       (RSC_NS),
      .REFRESH_COUNT (NREF),
      .REG_OUT       (LAT)
   ) u0 (
      .clk       (clk),
      .rst       (rst),
      .mode_cfg  (mode),
      .sd_cke    (sd_cke),
      .sd_cs_n   (sd_cs_n),
      .sd_ras_n  (sd_ras_n),
      .sd_cas_n  (sd_cas_n),
      .sd_we_n   (sd_we_n),
      .sd_ba     (sd_ba),
      .sd_addr   (sd_addr),
      .sd_dqm    (sd_dqm),
      .init_done (init_done)
   );

   wire [3:0] code = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // R8 codes: NOP 0111, PREA 0010, REF 0001, MRS 0000
   function automatic logic [3:0] exp_code(input int i);
      int b = i - LAT;
      if (b == S) return 4'b0010;
      if (b >= S + P && b < MRS_AT && ((b - S - P) % F) == 0) return 4'b0001;
      if (b == MRS_AT) return 4'b0000;
      return 4'b0111;
   endfunction

   function automatic string tag_of(input int i);
      int b = i - LAT;
      if (b <= S) return "R2";
      if (b == S + P) return "R3 R9";
      if (b > S + P && b < MRS_AT && ((b - S - P) % F) == 0) return "R4";
      if (b == MRS_AT) return "R5";
      return "R8";
   endfunction

   task automatic sample(input int i);
      logic [3:0] e = exp_code(i);
      bit         e_done = ((i - LAT) >= MRS_AT + M);
      chk(code == e, tag_of(i), 32'(code), 32'(e));
      chk(init_done == e_done, "R6", 32'(init_done), 32'(e_done));
      chk(sd_cke && (&sd_dqm), "R1", {23'd0, sd_cke, sd_dqm}, {23'd0, 1'b1, 8'hFF});
      if (e == 4'b0010)
         chk(sd_addr == 12'h400, "R2", 32'(sd_addr), 32'h400);
      if (e == 4'b0000)
         chk(sd_addr == {5'd0, mode} && sd_ba == 2'd0, "R5",
             {18'd0, sd_ba, sd_addr}, {25'd0, mode});
   endtask

   task automatic run_seq(input logic [6:0] m, input int stop);
      rst  = 1'b1;
      mode = m;
      repeat (2) @(negedge clk);
      // R1 reset state
      chk(code == 4'b0111 && !init_done && sd_cke && (&sd_dqm), "R1",
          {27'd0, init_done, code}, 32'h7);
      rst = 1'b0;
      for (int i = 0; i <= stop; i++) begin
         if (i > 0) @(negedge clk);
         sample(i);
      end
      if (stop < END_AT) begin
         rst = 1'b1;
         @(negedge clk);
         // R7 reset mid-sequence
         chk(code == 4'b0111 && !init_done, "R7", {27'd0, init_done, code}, 32'h7);
      end
   endtask

   initial begin
      #(CLK_NS * 200000);
      n_fail++;
      $display("FAIL watchdog R7: actual=running expected=finished");
      report();
   end

   initial begin
      run_seq(7'h00, END_AT);
      run_seq(7'h7F, END_AT);
      run_seq(7'h55, END_AT);
      run_seq(7'h2A, END_AT);
      for (int s = 0; s < END_AT; s += 3) begin
         run_seq(7'h33, s);
         // R7 restart after the mid-sequence reset
         run_seq(7'(s), END_AT);
      end
      report();
   end

endmodule